// File: doc/BRIEF.md
# Common-Interface Card Slot Bridge

This block turns simple register reads and writes from a host into byte-wide access cycles on two removable conditional-access card slots. The host first programs a 14-bit card address across two address registers, then picks the target slot and the address space (attribute memory or control/IO) in a bus control register. A read or write of the data register then launches exactly one card cycle on the chosen slot. The host handshake stalls until the card cycle completes, and a read returns the byte the card drove.

The same bus control register also carries three kinds of per-slot state. A reset request bit pulses the slot's reset line and then waits for the card's ready line. A transport-stream pass-through enable is driven straight to an output. A read-only card-absent status bit reflects the synchronized card-detect input. Any change of either card-detect input latches a pending interrupt, which the host clears by writing to an interrupt register.

The card side uses a plain strobe/wait handshake. A per-slot select stays high for a minimum number of cycles and then until the slot's wait input is low. If the card holds wait for too long, the cycle is abandoned after a bounded number of cycles.

Top module: `ci_slot_bridge`

## Requirements
- R1: Register map offsets: 0 is address-low, 1 is address-high, 2 is bus control, 3 is data, 4 is interrupt. Address-low bits 7:1 hold card address bits 6:0, and its bit 0 always reads 0. Address-high bits 6:0 hold card address bits 13:7, and its bit 7 always reads 0. The card address output equals {address-high[6:0], address-low[7:1]}.
- R2: Bus control bit 7 selects the slot (0 selects card_sel[0], 1 selects card_sel[1]). Bus control bit 6 selects the space: 1 is control/IO and 0 is attribute memory, and it is driven on card_space. At most one card_sel bit is high at any time.
- R3: Each host access to the data register produces exactly one card cycle on the selected slot, with the programmed address, space and direction. A write drives the host byte on card_wdata. A read returns the card_rdata byte sampled in the final strobe cycle. host_ack arrives one cycle after the strobe ends.
- R4: A card cycle keeps its select high for at least STROBE_MIN cycles, and then until the selected slot's card_wait is low. The select length is therefore max(STROBE_MIN, cycles the card waits). Address and space stay stable while the select is high.
- R5: If card_wait is still high after CYC_TIMEOUT strobe cycles, the cycle ends. A read then returns 0xFF.
- R6: Writing 1 to bus control bit 5 (slot 0) or bit 4 (slot 1) drives that slot's card_rst high for exactly RST_PULSE cycles, then waits for card_ready high. The bit reads 1 until that wait ends, and then reads 0.
- R7: If card_ready stays low, the reset bit clears itself RST_TIMEOUT cycles after the pulse ends.
- R8: Bus control bit 3 drives ts_en[0] (slot 0), and bit 2 drives ts_en[1] (slot 1). Both read back as written.
- R9: Bus control bit 1 reads the synchronized card_absent[0], and bit 0 reads card_absent[1] (1 means absent, 0 means present and ready). Host writes to these bits have no effect.
- R10: A change on either card_absent input sets the pending interrupt, which drives irq and reads as bit 0 of the interrupt register. Writing 1 to bit 0 of the interrupt register clears it.
- R11: After reset, irq, card_sel, card_rst and ts_en are 0, and bus control reads back with only the absent status bits set (for absent cards).
- R12: A non-data register access is acknowledged one cycle after the request is sampled, with a single-cycle host_ack pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_req | input | 1 | Host access request, held until host_ack |
| host_we | input | 1 | 1 = write, 0 = read |
| host_addr | input | 3 | Register offset |
| host_wdata | input | 8 | Host write byte |
| host_ack | output | 1 | One-cycle access completion |
| host_rdata | output | 8 | Read byte, valid with host_ack |
| card_sel | output | 2 | Per-slot cycle strobe |
| card_we | output | 1 | Card cycle direction, 1 = write |
| card_space | output | 1 | 1 = control/IO space, 0 = attribute memory |
| card_addr | output | 14 | Card address |
| card_wdata | output | 8 | Card write byte |
| card_rdata | input | 8 | Card read byte |
| card_wait | input | 2 | Per-slot wait, high extends the strobe |
| card_rst | output | 2 | Per-slot card reset |
| card_ready | input | 2 | Per-slot ready after reset |
| card_absent | input | 2 | Per-slot card-detect, 1 = absent |
| ts_en | output | 2 | Per-slot stream pass-through enable |
| irq | output | 1 | Pending card-detect change interrupt |

## Verification
The bench targets the strobe length at its edges: no wait (exactly STROBE_MIN cycles), a wait longer than the minimum, and a wait beyond the timeout. A design that ends the strobe early would hand back stale bytes, and one without a timeout would hang the host, which the watchdog turns into a failure. The scoreboard pairs every data-register access with exactly one observed strobe, carrying the right slot, space and the split address. This exposes a shifted address-low field or a doubled cycle. Reset bits are checked for pulse length, for staying set while the card is not ready, and for clearing both on ready and on timeout. The absent bits are checked to ignore writes, and the interrupt is checked to latch on a detect change and to clear on write.

// File: rtl/ci_bridge_pkg.sv
package ci_bridge_pkg;

  localparam int CARD_AW = 14;
  localparam int NSLOT   = 2;

  localparam logic [2:0] OFS_ADDR_LO = 3'd0;
  localparam logic [2:0] OFS_ADDR_HI = 3'd1;
  localparam logic [2:0] OFS_CTRL    = 3'd2;
  localparam logic [2:0] OFS_DATA    = 3'd3;
  localparam logic [2:0] OFS_IRQ     = 3'd4;

  typedef enum logic [1:0] {H_IDLE, H_CARD, H_ACK} host_st_t;
  typedef enum logic       {C_IDLE, C_ACTIVE}      card_st_t;
  typedef enum logic [1:0] {R_IDLE, R_PULSE, R_WAIT} rst_st_t;

  typedef struct packed {
    logic               slot;
    logic               space;
    logic               we;
    logic [CARD_AW-1:0] addr;
    logic [7:0]         wdata;
  } cyc_req_t;

endpackage

// File: rtl/ci_card_cycle.sv
module ci_card_cycle
  import ci_bridge_pkg::*;
#(
  parameter int STROBE_MIN  = 3,
  parameter int CYC_TIMEOUT = 64
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  cyc_req_t           req,
  input  logic [7:0]         card_rdata,
  input  logic [NSLOT-1:0]   card_wait,
  output logic               done,
  output logic [7:0]         done_rdata,
  output logic [NSLOT-1:0]   card_sel,
  output logic               card_we,
  output logic               card_space,
  output logic [CARD_AW-1:0] card_addr,
  output logic [7:0]         card_wdata
);

  localparam int CNT_W = $clog2(CYC_TIMEOUT + 1);
  localparam logic [CNT_W-1:0] MIN_LAST = CNT_W'(STROBE_MIN - 1);
  localparam logic [CNT_W-1:0] TMO_LAST = CNT_W'(CYC_TIMEOUT - 1);

  card_st_t         st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  cyc_req_t         cur_q;
  logic             cur_en;
  logic             finish_ok, finish_tmo;

  assign finish_ok  = (st_q == C_ACTIVE) && (cnt_q >= MIN_LAST) && !card_wait[cur_q.slot];
  assign finish_tmo = (st_q == C_ACTIVE) && !finish_ok && (cnt_q == TMO_LAST);
  assign cur_en     = (st_q == C_IDLE) && start;

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    case (st_q)
      C_IDLE: begin
        cnt_d = '0;
        if (start) st_d = C_ACTIVE;
      end
      C_ACTIVE: begin
        if (finish_ok || finish_tmo) begin
          st_d  = C_IDLE;
          cnt_d = '0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      default: st_d = C_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= C_IDLE;
      cnt_q <= '0;
      cur_q <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
      if (cur_en) cur_q <= req;
    end
  end

  assign done       = finish_ok || finish_tmo;
  assign done_rdata = finish_ok ? card_rdata : 8'hFF;
  assign card_sel   = (st_q == C_ACTIVE) ? (NSLOT'(1) << cur_q.slot) : '0;
  assign card_we    = cur_q.we;
  assign card_space = cur_q.space;
  assign card_addr  = cur_q.addr;
  assign card_wdata = cur_q.wdata;

endmodule

// File: rtl/ci_slot_reset.sv
module ci_slot_reset
  import ci_bridge_pkg::*;
#(
  parameter int RST_PULSE   = 16,
  parameter int RST_TIMEOUT = 1 << 20
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic card_ready,
  output logic busy,
  output logic card_rst
);

  localparam int CMAX  = (RST_PULSE > RST_TIMEOUT) ? RST_PULSE : RST_TIMEOUT;
  localparam int CNT_W = $clog2(CMAX + 1);
  localparam logic [CNT_W-1:0] PULSE_LAST = CNT_W'(RST_PULSE - 1);
  localparam logic [CNT_W-1:0] TMO_LAST   = CNT_W'(RST_TIMEOUT - 1);

  rst_st_t          st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    case (st_q)
      R_IDLE: begin
        cnt_d = '0;
        if (start) st_d = R_PULSE;
      end
      R_PULSE: begin
        if (cnt_q == PULSE_LAST) begin
          st_d  = R_WAIT;
          cnt_d = '0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      R_WAIT: begin
        if (card_ready || (cnt_q == TMO_LAST)) begin
          st_d  = R_IDLE;
          cnt_d = '0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      default: st_d = R_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= R_IDLE;
      cnt_q <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
    end
  end

  assign busy     = (st_q != R_IDLE);
  assign card_rst = (st_q == R_PULSE);

endmodule

// File: rtl/ci_detect.sv
module ci_detect
  import ci_bridge_pkg::*;
#(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] absent_in,
  input  logic         clr,
  output logic [N-1:0] absent_s,
  output logic         pend
);

  logic [N-1:0] s1_q, s2_q, s3_q;
  logic         pend_q, pend_d;
  logic         changed;

  assign changed = |(s2_q ^ s3_q);

  always_comb begin
    pend_d = pend_q;
    if (clr)     pend_d = 1'b0;
    if (changed) pend_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q   <= '1;
      s2_q   <= '1;
      s3_q   <= '1;
      pend_q <= 1'b0;
    end else begin
      s1_q   <= absent_in;
      s2_q   <= s1_q;
      s3_q   <= s2_q;
      pend_q <= pend_d;
    end
  end

  assign absent_s = s2_q;
  assign pend     = pend_q;

endmodule

// File: rtl/ci_slot_bridge.sv
module ci_slot_bridge
  import ci_bridge_pkg::*;
#(
  parameter int STROBE_MIN  = 3,
  parameter int CYC_TIMEOUT = 64,
  parameter int RST_PULSE   = 16,
  parameter int RST_TIMEOUT = 1 << 20
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               host_req,
  input  logic               host_we,
  input  logic [2:0]         host_addr,
  input  logic [7:0]         host_wdata,
  output logic               host_ack,
  output logic [7:0]         host_rdata,
  output logic [1:0]         card_sel,
  output logic               card_we,
  output logic               card_space,
  output logic [13:0]        card_addr,
  output logic [7:0]         card_wdata,
  input  logic [7:0]         card_rdata,
  input  logic [1:0]         card_wait,
  output logic [1:0]         card_rst,
  input  logic [1:0]         card_ready,
  input  logic [1:0]         card_absent,
  output logic [1:0]         ts_en,
  output logic               irq
);

  localparam int LO_W = 7;
  localparam int HI_W = CARD_AW - LO_W;

  host_st_t        hst_q, hst_d;
  logic [LO_W-1:0] addr_lo_q;
  logic [HI_W-1:0] addr_hi_q;
  logic            slot_q, space_q;
  logic [1:0]      ts_q;
  logic [7:0]      rdata_q, rdata_d;
  logic            rdata_en;

  logic            acc, wr_acc, rd_reg_acc;
  logic            wr_lo, wr_hi, wr_ctrl, wr_irq, start_card;
  logic [1:0]      rst_busy, rst_start;
  logic [1:0]      absent_s;
  logic            pend;
  logic            cyc_done;
  logic [7:0]      cyc_rdata;
  logic [7:0]      ctrl_view, reg_view;
  cyc_req_t        cyc_req;

  assign acc        = (hst_q == H_IDLE) && host_req;
  assign wr_acc     = acc && host_we;
  assign rd_reg_acc = acc && (host_addr != OFS_DATA);
  assign wr_lo      = wr_acc && (host_addr == OFS_ADDR_LO);
  assign wr_hi      = wr_acc && (host_addr == OFS_ADDR_HI);
  assign wr_ctrl    = wr_acc && (host_addr == OFS_CTRL);
  assign wr_irq     = wr_acc && (host_addr == OFS_IRQ) && host_wdata[0];
  assign start_card = acc && (host_addr == OFS_DATA);

  assign rst_start[0] = wr_ctrl && host_wdata[5] && !rst_busy[0];
  assign rst_start[1] = wr_ctrl && host_wdata[4] && !rst_busy[1];

  assign ctrl_view = {slot_q, space_q, rst_busy[0], rst_busy[1],
                      ts_q[0], ts_q[1], absent_s[0], absent_s[1]};

  always_comb begin
    case (host_addr)
      OFS_ADDR_LO: reg_view = {addr_lo_q, 1'b0};
      OFS_ADDR_HI: reg_view = {1'b0, addr_hi_q};
      OFS_CTRL:    reg_view = ctrl_view;
      OFS_IRQ:     reg_view = {7'd0, pend};
      default:     reg_view = 8'd0;
    endcase
  end

  always_comb begin
    cyc_req.slot  = slot_q;
    cyc_req.space = space_q;
    cyc_req.we    = host_we;
    cyc_req.addr  = {addr_hi_q, addr_lo_q};
    cyc_req.wdata = host_wdata;
  end

  // host-side sequencing
  always_comb begin
    hst_d    = hst_q;
    rdata_en = 1'b0;
    rdata_d  = rdata_q;
    case (hst_q)
      H_IDLE: begin
        if (start_card) begin
          hst_d = H_CARD;
        end else if (acc) begin
          hst_d = H_ACK;
          if (rd_reg_acc && !host_we) begin
            rdata_en = 1'b1;
            rdata_d  = reg_view;
          end
        end
      end
      H_CARD: begin
        if (cyc_done) begin
          hst_d    = H_ACK;
          rdata_en = !card_we;
          rdata_d  = cyc_rdata;
        end
      end
      H_ACK:   hst_d = H_IDLE;
      default: hst_d = H_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hst_q     <= H_IDLE;
      rdata_q   <= '0;
      addr_lo_q <= '0;
      addr_hi_q <= '0;
      slot_q    <= 1'b0;
      space_q   <= 1'b0;
      ts_q      <= '0;
    end else begin
      hst_q <= hst_d;
      if (rdata_en) rdata_q <= rdata_d;
      if (wr_lo)    addr_lo_q <= host_wdata[7:1];
      if (wr_hi)    addr_hi_q <= host_wdata[HI_W-1:0];
      if (wr_ctrl) begin
        slot_q  <= host_wdata[7];
        space_q <= host_wdata[6];
        ts_q    <= {host_wdata[2], host_wdata[3]};
      end
    end
  end

  assign host_ack   = (hst_q == H_ACK);
  assign host_rdata = rdata_q;
  assign ts_en      = ts_q;
  assign irq        = pend;

  ci_card_cycle #(
    .STROBE_MIN (STROBE_MIN),
    .CYC_TIMEOUT(CYC_TIMEOUT)
  ) u_cycle (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start_card),
    .req       (cyc_req),
    .card_rdata(card_rdata),
    .card_wait (card_wait),
    .done      (cyc_done),
    .done_rdata(cyc_rdata),
    .card_sel  (card_sel),
    .card_we   (card_we),
    .card_space(card_space),
    .card_addr (card_addr),
    .card_wdata(card_wdata)
  );

  for (genvar g = 0; g < NSLOT; g++) begin : g_rst
    ci_slot_reset #(
      .RST_PULSE  (RST_PULSE),
      .RST_TIMEOUT(RST_TIMEOUT)
    ) u_rst (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (rst_start[g]),
      .card_ready(card_ready[g]),
      .busy      (rst_busy[g]),
      .card_rst  (card_rst[g])
    );
  end

  ci_detect #(.N(NSLOT)) u_det (
    .clk      (clk),
    .rst_n    (rst_n),
    .absent_in(card_absent),
    .clr      (wr_irq),
    .absent_s (absent_s),
    .pend     (pend)
  );

endmodule

// File: rtl/ci_slot_bridge_chk.sv
module ci_slot_bridge_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [1:0]  card_sel,
  input logic [13:0] card_addr,
  input logic        card_space,
  input logic        host_ack,
  input logic [1:0]  card_rst,
  input logic [1:0]  rst_busy,
  input logic [1:0]  absent_s,
  input logic        irq
);

  p_sel_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(card_sel));

  p_addr_stable_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ((|card_sel) && $past(|card_sel)) |-> ($stable(card_addr) && $stable(card_space)));

  p_ack_single_r12: assert property (@(posedge clk) disable iff (!rst_n)
    host_ack |=> !host_ack);

  p_rst_done_after_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rst_busy[0]) |-> !card_rst[0]);

  p_rst_line_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
    card_rst[1] |-> rst_busy[1]);

  p_irq_on_change_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(absent_s) |=> irq);

endmodule

bind ci_slot_bridge ci_slot_bridge_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .card_sel  (card_sel),
  .card_addr (card_addr),
  .card_space(card_space),
  .host_ack  (host_ack),
  .card_rst  (card_rst),
  .rst_busy  (rst_busy),
  .absent_s  (absent_s),
  .irq       (irq)
);

// File: tb/ci_slot_bridge_bench.sv
`timescale 1ns/1ps
module ci_slot_bridge_bench;

  localparam int SMIN = 3;
  localparam int CTMO = 64;
  localparam int RPUL = 8;
  localparam int RTMO = 200;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        host_req, host_we;
  logic [2:0]  host_addr;
  logic [7:0]  host_wdata;
  logic        host_ack;
  logic [7:0]  host_rdata;
  logic [1:0]  card_sel;
  logic        card_we, card_space;
  logic [13:0] card_addr;
  logic [7:0]  card_wdata, card_rdata;
  logic [1:0]  card_wait, card_rst, card_ready, card_absent, ts_en;
  logic        irq;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;
  int wait_len = 0;
  int sel_cnt = 0;

  typedef struct {
    logic       slot;
    logic       space;
    logic       we;
    logic [13:0] addr;
    logic [7:0] wdata;
    int         len;
  } exp_t;
  exp_t sb_q[$];
  exp_t cur;
  logic mon_active = 1'b0;
  int   mon_len = 0;

  always #2 clk = ~clk;

  ci_slot_bridge #(
    .STROBE_MIN(SMIN), .CYC_TIMEOUT(CTMO), .RST_PULSE(RPUL), .RST_TIMEOUT(RTMO)
  ) u_ci_slot_bridge (
    .clk(clk), .rst_n(rst_n), .host_req(host_req), .host_we(host_we),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_ack(host_ack),
    .host_rdata(host_rdata), .card_sel(card_sel), .card_we(card_we),
    .card_space(card_space), .card_addr(card_addr), .card_wdata(card_wdata),
    .card_rdata(card_rdata), .card_wait(card_wait), .card_rst(card_rst),
    .card_ready(card_ready), .card_absent(card_absent), .ts_en(ts_en), .irq(irq)
  );

  // card model: data depends on address, space and slot
  assign card_rdata = card_addr[7:0] ^ {card_space, 7'd0} ^ (card_sel[1] ? 8'h5A : 8'h00);

  always @(negedge clk) begin
    if (|card_sel) begin
      sel_cnt   = sel_cnt + 1;
      card_wait = (sel_cnt < wait_len) ? 2'b11 : 2'b00;
    end else begin
      sel_cnt   = 0;
      card_wait = 2'b11;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // monitor: pops one expected card cycle per observed strobe
  always @(negedge clk) begin
    if (rst_n) begin
      if ((|card_sel) && !mon_active) begin
        mon_active = 1'b1;
        mon_len    = 1;
        if (sb_q.size() == 0) begin
          check(1'b0, "R3 unexpected card cycle", int'(card_sel), 0);
        end else begin
          cur = sb_q.pop_front();
          check(card_sel == (cur.slot ? 2'b10 : 2'b01), "R2 slot select", int'(card_sel), cur.slot ? 2 : 1);
          check(card_space == cur.space, "R2 space", int'(card_space), int'(cur.space));
          check(card_addr == cur.addr, "R1 card address", int'(card_addr), int'(cur.addr));
          check(card_we == cur.we, "R3 direction", int'(card_we), int'(cur.we));
          if (cur.we) check(card_wdata == cur.wdata, "R3 write data", int'(card_wdata), int'(cur.wdata));
        end
      end else if ((|card_sel) && mon_active) begin
        mon_len++;
      end else if (!(|card_sel) && mon_active) begin
        mon_active = 1'b0;
        check(mon_len == cur.len, "R4 strobe length", mon_len, cur.len);
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=%0d expected<150000", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  task automatic xfer(input logic [2:0] a, input logic we, input logic [7:0] wd,
                      output logic [7:0] rd, output int lat);
    @(negedge clk);
    host_req = 1'b1; host_addr = a; host_we = we; host_wdata = wd;
    lat = 0;
    do begin
      @(negedge clk);
      lat++;
    end while (!host_ack);
    rd = host_rdata;
    host_req = 1'b0;
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    logic [7:0] r; int l;
    xfer(a, 1'b1, d, r, l);
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    int l;
    xfer(a, 1'b0, 8'h00, d, l);
  endtask

  task automatic card_op(input logic slot, input logic space, input logic [13:0] addr,
                         input logic we, input logic [7:0] wd, input int w);
    exp_t e; logic [7:0] r; int l; logic [7:0] ex;
    int len;
    bit tmo;
    wr(3'd0, {addr[6:0], 1'b0});
    wr(3'd1, {1'b0, addr[13:7]});
    wr(3'd2, {slot, space, 6'd0});
    wait_len = w;
    tmo = (w > CTMO);
    len = tmo ? CTMO : ((w > SMIN) ? w : SMIN);
    e.slot = slot; e.space = space; e.we = we; e.addr = addr; e.wdata = wd; e.len = len;
    sb_q.push_back(e);
    xfer(3'd3, we, wd, r, l);
    check(l == len + 1, "R3 data access latency", l, len + 1);
    if (!we) begin
      ex = tmo ? 8'hFF : (addr[7:0] ^ {space, 7'd0} ^ (slot ? 8'h5A : 8'h00));
      check(r == ex, tmo ? "R5 timeout read" : "R3 read data", int'(r), int'(ex));
    end
  endtask

  initial begin
    logic [7:0] r;
    int l;
    int n;
    rst_n = 1'b0; host_req = 1'b0; host_we = 1'b0; host_addr = '0; host_wdata = '0;
    card_ready = 2'b00; card_absent = 2'b11; card_wait = 2'b11;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R11 reset state
    check(irq == 1'b0 && card_sel == 2'b00 && card_rst == 2'b00 && ts_en == 2'b00,
          "R11 idle outputs", int'({irq, card_sel, card_rst, ts_en}), 0);
    rd(3'd2, r); check(r == 8'h03, "R11 ctrl reset value", int'(r), 8'h03);
    rd(3'd4, r); check(r == 8'h00, "R11 irq reg reset value", int'(r), 0);

    // R12 register access latency
    xfer(3'd0, 1'b1, 8'hFF, r, l);
    check(l == 1, "R12 register ack latency", l, 1);
    rd(3'd0, r); check(r == 8'hFE, "R1 addr low bit0 reads 0", int'(r), 8'hFE);
    wr(3'd1, 8'hFF);
    rd(3'd1, r); check(r == 8'h7F, "R1 addr high bit7 reads 0", int'(r), 8'h7F);

    // R8 stream enables
    wr(3'd2, 8'h0C);
    check(ts_en == 2'b11, "R8 both enables", int'(ts_en), 3);
    rd(3'd2, r); check(r == 8'h0F, "R8 readback", int'(r), 8'h0F);
    wr(3'd2, 8'h08);
    check(ts_en == 2'b01, "R8 slot0 enable only", int'(ts_en), 1);
    wr(3'd2, 8'h04);
    check(ts_en == 2'b10, "R8 slot1 enable only", int'(ts_en), 2);

    // R9 absent bits ignore writes
    wr(3'd2, 8'h00);
    rd(3'd2, r); check(r[1:0] == 2'b11, "R9 absent bits not writable", int'(r[1:0]), 3);

    // R3 / R4 / R2 card cycles
    card_op(1'b0, 1'b0, 14'h1234, 1'b1, 8'hA5, 0);
    card_op(1'b0, 1'b0, 14'h1234, 1'b0, 8'h00, 0);
    card_op(1'b1, 1'b1, 14'h3FFF, 1'b0, 8'h00, 0);
    card_op(1'b1, 1'b0, 14'h0081, 1'b1, 8'h3C, 6);
    card_op(1'b0, 1'b1, 14'h2A55, 1'b0, 8'h00, 9);
    card_op(1'b1, 1'b1, 14'h0001, 1'b0, 8'h00, 2);

    // R5 timeout
    card_op(1'b0, 1'b1, 14'h0100, 1'b0, 8'h00, 100);
    card_op(1'b1, 1'b0, 14'h0200, 1'b1, 8'h77, 100);
    wait_len = 0;
    repeat (4) @(negedge clk);
    check(sb_q.size() == 0, "R3 one cycle per access", sb_q.size(), 0);

    // R6 reset with ready
    card_ready = 2'b00;
    wr(3'd2, 8'h20);
    check(card_rst[1] == 1'b0, "R6 other slot untouched", int'(card_rst[1]), 0);
    n = 0;
    while (card_rst[0] && n < 1000) begin n++; @(negedge clk); end
    check(n == RPUL, "R6 pulse length", n, RPUL);
    rd(3'd2, r); check(r[5] == 1'b1, "R6 bit held while not ready", int'(r[5]), 1);
    card_ready[0] = 1'b1;
    repeat (3) @(negedge clk);
    rd(3'd2, r); check(r[5] == 1'b0, "R6 bit clears on ready", int'(r[5]), 0);

    // R7 reset timeout
    card_ready[1] = 1'b0;
    wr(3'd2, 8'h10);
    check(card_rst[1] == 1'b1, "R7 slot1 reset line", int'(card_rst[1]), 1);
    repeat (150) @(negedge clk);
    rd(3'd2, r); check(r[4] == 1'b1, "R7 still busy before timeout", int'(r[4]), 1);
    repeat (80) @(negedge clk);
    rd(3'd2, r); check(r[4] == 1'b0, "R7 cleared by timeout", int'(r[4]), 0);

    // R10 detect interrupt
    card_absent = 2'b10;
    repeat (5) @(negedge clk);
    check(irq == 1'b1, "R10 irq on slot0 change", int'(irq), 1);
    rd(3'd4, r); check(r == 8'h01, "R10 pending reads 1", int'(r), 1);
    rd(3'd2, r); check(r[1:0] == 2'b01, "R9 slot0 present status", int'(r[1:0]), 1);
    wr(3'd4, 8'h01);
    check(irq == 1'b0, "R10 write clears", int'(irq), 0);
    card_absent = 2'b00;
    repeat (5) @(negedge clk);
    check(irq == 1'b1, "R10 irq on slot1 change", int'(irq), 1);
    wr(3'd4, 8'h01);
    check(irq == 1'b0, "R10 second clear", int'(irq), 0);

    repeat (4) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule